// File: doc/BRIEF.md
# Per-Pin Interrupt Trigger Detector

This block turns eight (by default) general-purpose input pins into a single port interrupt request. Each pin has its own trigger setting, built from three configuration bits: one picks level or edge sensing, one asks for both edges, and one sets the polarity. Together they give five trigger kinds: falling edge, rising edge, any edge, low level and high level. Pin values first pass through a two-flop synchronizer. A third flop holds the previous synchronized value, which is what edge detection compares against.

Edge events set a sticky flag for the pin. Software clears that flag by writing a one to the matching bit of a clear register. A level-sensed pin has no flag to clear: its status follows the synchronized pin for as long as the level lasts. An enable register gates the raw status into a masked status. The masked bits are ORed and registered to drive the port interrupt line. Software programs the block and reads both status words through a simple register port, with a one-cycle write strobe and a combinational read.

Top module: `pin_irq_detect`

## Requirements
- R1: With level sensing selected (level-select bit = 1), a pin's raw status bit is 1 while its synchronized value is low for polarity 0, or high for polarity 1. The status follows the pin with no latching.
- R2: With edge sensing and the any-edge bit = 1, both a rising and a falling transition set the pin's edge flag, whatever the polarity bit holds.
- R3: With edge sensing and the any-edge bit = 0, polarity 0 sets the flag on a falling transition only, and polarity 1 sets it on a rising transition only.
- R4: An edge flag stays set until a 1 is written to its bit of the clear register (address 6). Zero bits in that write leave their flags untouched.
- R5: A clear write has no effect on a level-sensed pin: its raw status stays 1 while the active level persists.
- R6: If an edge is detected in the same cycle as a clear write to that pin, the flag ends the cycle set.
- R7: Masked status equals raw status AND the enable register. `irq_out` is the OR of the masked bits and appears one clock after the raw status that produces it.
- R8: After reset, all configuration registers, edge flags and `irq_out` are 0.
- R9: A change on a pin reaches the raw status of a level-sensed pin after exactly two rising clock edges, and reaches `irq_out` one edge later.
- R10: The register map is: 0 level select, 1 any-edge, 2 polarity, 3 enable, 4 raw status, 5 masked status, 6 clear. Configuration registers read back what was written. The clear address reads 0. Writes to the two status addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NPINS | Asynchronous pin values |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Write register select |
| wr_data | input | NPINS | Write data, one bit per pin |
| rd_addr | input | 3 | Read register select |
| rd_data | output | NPINS | Combinational read data |
| irq_out | output | 1 | Registered port interrupt request |

## Verification
The main sweep uses five configuration passes. In each pass every pin takes a different trigger kind, so over the whole sweep every pin meets all five. Twelve pin patterns are driven in each pass, with a mix of all-ones, all-zeros, alternating and half-word values. This produces rising, falling and unchanged pins side by side, which separates the rising-edge, falling-edge and any-edge detectors from each other and from the level modes. Partial clears between patterns show that edge flags drop only where a one is written, while level pins keep their status. Directed cases cover the following:
- the two-edge synchronizer latency, measured against a single pin change;
- an edge that lands in the same cycle as a clear;
- register readback, the reads-as-zero clear address, and the ignored writes to status addresses.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_LEVEL_SEL = 3'd0,
        RA_ANY_EDGE  = 3'd1,
        RA_POLARITY  = 3'd2,
        RA_ENABLE    = 3'd3,
        RA_RAW       = 3'd4,
        RA_MASKED    = 3'd5,
        RA_CLEAR     = 3'd6
    } reg_addr_e;

    typedef enum logic [2:0] {
        TRIG_FALL,
        TRIG_RISE,
        TRIG_ANY_EDGE,
        TRIG_LOW,
        TRIG_HIGH
    } trig_e;

    typedef struct packed {
        logic lvl;
        logic any;
        logic pol;
    } pin_cfg_t;

    function automatic trig_e decode_trig(pin_cfg_t c);
        if (c.lvl)      return c.pol ? TRIG_HIGH : TRIG_LOW;
        else if (c.any) return TRIG_ANY_EDGE;
        else            return c.pol ? TRIG_RISE : TRIG_FALL;
    endfunction

    function automatic logic is_level(trig_e m);
        return (m == TRIG_LOW) || (m == TRIG_HIGH);
    endfunction

    function automatic logic edge_event(trig_e m, logic cur, logic prev);
        case (m)
            TRIG_FALL:     return prev & ~cur;
            TRIG_RISE:     return ~prev & cur;
            TRIG_ANY_EDGE: return prev ^ cur;
            default:       return 1'b0;
        endcase
    endfunction

    function automatic logic level_active(trig_e m, logic cur);
        return (m == TRIG_HIGH) ? cur : ~cur;
    endfunction

endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
    parameter int NPINS  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_i,
    output logic [NPINS-1:0] sync_o,
    output logic [NPINS-1:0] prev_o
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0][NPINS-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[DEPTH-2:0], pin_i};
    end

    assign sync_o = chain_q[STAGES-1];
    assign prev_o = chain_q[STAGES];
endmodule

// File: rtl/pirq_regs.sv
module pirq_regs
    import pirq_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NPINS-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [NPINS-1:0]  raw_i,
    input  logic [NPINS-1:0]  masked_i,
    output pin_cfg_t [NPINS-1:0] cfg_o,
    output logic [NPINS-1:0]  en_o,
    output logic [NPINS-1:0]  clr_o,
    output logic [NPINS-1:0]  rd_data
);
    logic [NPINS-1:0] lvl_q, any_q, pol_q, en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
            any_q <= '0;
            pol_q <= '0;
            en_q  <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                RA_LEVEL_SEL: lvl_q <= wr_data;
                RA_ANY_EDGE:  any_q <= wr_data;
                RA_POLARITY:  pol_q <= wr_data;
                RA_ENABLE:    en_q  <= wr_data;
                default:      ;
            endcase
        end
    end

    assign clr_o = (wr_en && (reg_addr_e'(wr_addr) == RA_CLEAR)) ? wr_data : '0;
    assign en_o  = en_q;

    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_cfg
            assign cfg_o[i] = '{lvl: lvl_q[i], any: any_q[i], pol: pol_q[i]};
        end
    endgenerate

    always_comb begin
        case (reg_addr_e'(rd_addr))
            RA_LEVEL_SEL: rd_data = lvl_q;
            RA_ANY_EDGE:  rd_data = any_q;
            RA_POLARITY:  rd_data = pol_q;
            RA_ENABLE:    rd_data = en_q;
            RA_RAW:       rd_data = raw_i;
            RA_MASKED:    rd_data = masked_i;
            default:      rd_data = '0;
        endcase
    end
endmodule

// File: rtl/pirq_detect.sv
module pirq_detect
    import pirq_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  pin_cfg_t [NPINS-1:0] cfg_i,
    input  logic [NPINS-1:0]     sync_i,
    input  logic [NPINS-1:0]     prev_i,
    input  logic [NPINS-1:0]     clr_i,
    output logic [NPINS-1:0]     ev_o,
    output logic [NPINS-1:0]     flag_o,
    output logic [NPINS-1:0]     raw_o
);
    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_pin
            trig_e mode;
            logic  flag_q;

            assign mode    = decode_trig(cfg_i[i]);
            assign ev_o[i] = edge_event(mode, sync_i[i], prev_i[i]);

            always_ff @(posedge clk) begin
                if (rst) flag_q <= 1'b0;
                else     flag_q <= ev_o[i] | (flag_q & ~clr_i[i]);
            end

            assign flag_o[i] = flag_q;
            assign raw_o[i]  = is_level(mode) ? level_active(mode, sync_i[i]) : flag_q;
        end
    endgenerate
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
    import pirq_pkg::*;
#(
    parameter int NPINS       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPINS-1:0]  pin_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NPINS-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [NPINS-1:0]  rd_data,
    output logic              irq_out
);
    pin_cfg_t [NPINS-1:0] cfg;
    logic [NPINS-1:0] sync_q, prev_q, ev_bits, edge_flags, clr_bits;
    logic [NPINS-1:0] raw_st, masked_st, en_bits;
    logic             irq_q;

    pirq_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (pin_in),
        .sync_o (sync_q),
        .prev_o (prev_q)
    );

    pirq_regs #(.NPINS(NPINS)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .raw_i    (raw_st),
        .masked_i (masked_st),
        .cfg_o    (cfg),
        .en_o     (en_bits),
        .clr_o    (clr_bits),
        .rd_data  (rd_data)
    );

    pirq_detect #(.NPINS(NPINS)) u_det (
        .clk    (clk),
        .rst    (rst),
        .cfg_i  (cfg),
        .sync_i (sync_q),
        .prev_i (prev_q),
        .clr_i  (clr_bits),
        .ev_o   (ev_bits),
        .flag_o (edge_flags),
        .raw_o  (raw_st)
    );

    assign masked_st = raw_st & en_bits;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |masked_st;
    end

    assign irq_out = irq_q;
endmodule

// File: rtl/pirq_chk.sv
module pirq_chk #(
    parameter int NPINS = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [NPINS-1:0] sync_q,
    input logic [NPINS-1:0] prev_q,
    input logic [NPINS-1:0] ev_bits,
    input logic [NPINS-1:0] edge_flags,
    input logic [NPINS-1:0] clr_bits,
    input logic [NPINS-1:0] raw_st,
    input logic [NPINS-1:0] en_bits,
    input logic             irq_out
);
    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (irq_out == 1'b0 && edge_flags == '0));

    // R7
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_out == |($past(raw_st & en_bits))));

    // R4
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(edge_flags) & ~$past(clr_bits)) & ~edge_flags) == '0));

    // R6
    clear_race_chk: assert property (@(posedge clk) disable iff (rst)
        ((ev_bits & clr_bits) != '0) |=>
            ((edge_flags & $past(ev_bits & clr_bits)) == $past(ev_bits & clr_bits)));

    // R2 R3
    flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((edge_flags & ~$past(edge_flags)) & ~$past(sync_q ^ prev_q)) == '0));
endmodule

bind pin_irq_detect pirq_chk #(.NPINS(NPINS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sync_q     (sync_q),
    .prev_q     (prev_q),
    .ev_bits    (ev_bits),
    .edge_flags (edge_flags),
    .clr_bits   (clr_bits),
    .raw_st     (raw_st),
    .en_bits    (en_bits),
    .irq_out    (irq_out)
);

// File: tb/tb_pin_irq_detect.sv
module tb_pin_irq_detect;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] pin_in = '0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [N-1:0] wr_data = '0;
    logic [2:0]   rd_addr = '0;
    logic [N-1:0] rd_data;
    logic         irq_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [N-1:0] m_lvl, m_any, m_pol, m_en, m_flag, m_pin;

    pin_irq_detect #(.NPINS(N)) dut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [N-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [N-1:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    function automatic logic [N-1:0] exp_raw();
        logic [N-1:0] r;
        for (int i = 0; i < N; i++)
            r[i] = m_lvl[i] ? (m_pol[i] ? m_pin[i] : ~m_pin[i]) : m_flag[i];
        return r;
    endfunction

    task automatic drive_pins(logic [N-1:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (5) @(negedge clk);
        for (int i = 0; i < N; i++) begin
            logic ev;
            if (m_any[i]) ev = m_pin[i] ^ v[i];
            else if (m_pol[i]) ev = ~m_pin[i] & v[i];
            else ev = m_pin[i] & ~v[i];
            if (!m_lvl[i] && ev) m_flag[i] = 1'b1;
        end
        m_pin = v;
    endtask

    task automatic check_status(string req);
        logic [N-1:0] d;
        rd(3'd4, d);
        check(req, d, exp_raw());
        rd(3'd5, d);
        check("R7 masked", d, exp_raw() & m_en);
        check("R7 irq", irq_out, |(exp_raw() & m_en));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] d;
        logic [N-1:0] pats [12];
        pats = '{8'h00, 8'hFF, 8'h00, 8'hA5, 8'h5A, 8'h0F, 8'hF0, 8'hF0,
                 8'h33, 8'hCC, 8'hFF, 8'h81};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R8 reset state
        for (int a = 0; a < 7; a++) begin
            rd(a[2:0], d);
            check("R8 reset reg", d, 0);
        end
        check("R8 reset irq", irq_out, 0);

        // R10 readback, clear reads zero, status writes ignored
        wr(3'd0, 8'h5C); wr(3'd1, 8'hA3); wr(3'd2, 8'h96); wr(3'd3, 8'h69);
        rd(3'd0, d); check("R10 level sel", d, 8'h5C);
        rd(3'd1, d); check("R10 any edge", d, 8'hA3);
        rd(3'd2, d); check("R10 polarity", d, 8'h96);
        rd(3'd3, d); check("R10 enable", d, 8'h69);
        wr(3'd6, 8'hFF);
        rd(3'd6, d); check("R10 clear reads 0", d, 0);
        wr(3'd0, 8'hFF); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
        wr(3'd4, 8'h00);
        rd(3'd4, d); check("R10 raw write ignored", d, 8'hFF);
        wr(3'd5, 8'hFF);
        rd(3'd5, d); check("R10 masked write ignored", d, 8'h00);

        // R9 latency: level-high on all, single pin change
        wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
        repeat (3) @(negedge clk);
        pin_in = 8'h01;
        @(negedge clk);
        rd(3'd4, d); check("R9 one edge", d, 8'h00);
        check("R9 irq one edge", irq_out, 0);
        @(negedge clk);
        rd(3'd4, d); check("R9 two edges", d, 8'h01);
        check("R9 irq two edges", irq_out, 0);
        @(negedge clk);
        check("R9 irq three edges", irq_out, 1);
        pin_in = 8'h00;
        repeat (4) @(negedge clk);

        // R6 edge coinciding with clear: pin 0 rising edge mode
        wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h01);
        wr(3'd6, 8'hFF);
        @(negedge clk);
        pin_in = 8'h01;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd6; wr_data = 8'h01;
        @(negedge clk);
        wr_en = 1'b0;
        rd(3'd4, d); check("R6 flag survives clear", d, 8'h01);
        wr(3'd6, 8'h01);
        rd(3'd4, d); check("R4 later clear drops flag", d, 8'h00);
        pin_in = 8'h00;
        repeat (4) @(negedge clk);
        rd(3'd4, d); check("R3 falling ignored in rise mode", d, 8'h00);

        // Sweep: each pin cycles through all five trigger kinds
        m_pin = 8'h00;
        for (int k = 0; k < 5; k++) begin
            for (int i = 0; i < N; i++) begin
                int m;
                m = (i + k) % 5;
                m_lvl[i] = (m >= 3);
                m_any[i] = (m == 2) ? 1'b1 : ((m >= 3) ? i[0] : 1'b0);
                m_pol[i] = (m == 0) ? 1'b0 : (m == 1) ? 1'b1 : (m == 2) ? i[1] : (m == 4);
            end
            m_en = (k == 0) ? 8'hFF : (8'h5A ^ (8'(k) * 8'h11));
            wr(3'd0, m_lvl); wr(3'd1, m_any); wr(3'd2, m_pol); wr(3'd3, m_en);
            wr(3'd6, 8'hFF);
            m_flag = '0;
            repeat (2) @(negedge clk);
            check_status("R1 R2 R3 after config");
            for (int j = 0; j < 12; j++) begin
                drive_pins(pats[j]);
                check_status("R1 R2 R3 pattern");
                if (j % 3 == 2) begin
                    logic [N-1:0] c;
                    c = pats[j] ^ 8'hC3;
                    wr(3'd6, c);
                    m_flag = m_flag & ~c;
                    @(negedge clk);
                    check_status("R4 R5 after clear");
                end
            end
            drive_pins(8'h00);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule